// File: doc/BRIEF.md
# Multi-Target Interrupt Router

This block gathers 64 interrupt sources, arranged as a legacy bank and an extended bank of 32 lines each, and distributes every one of them to four processor targets: three application cores and one I/O processor. Each target latches its own copy of every source in sticky pending flags. Software clears a flag by writing a one to it. Per-target enable masks decide which pending flags drive that target's interrupt line. The I/O-processor target has a second set of enable masks, and these drive a separate fast-interrupt line.

Sources are sampled on the rising clock edge. A low-to-high change on a source sets the matching pending bit in all four targets at once. Software reaches every register through a plain 32-bit read/write bus with byte offsets. Read data comes back one cycle after the read strobe. The interrupt and fast-interrupt outputs are registered and follow their pending and enable state with one cycle of delay.

Top module: `irq_router`

## Requirements
- R1: After reset, every pending and enable register reads zero, and `irq_o` and `fiq_o` are zero.
- R2: A rising edge on a source line sets the matching pending bit in all four targets (legacy bank: bit n of `src_legacy_i`; extended bank: bit n of `src_ext_i`). A source held high does not set a pending bit again after software has cleared it.
- R3: Writing a pending register clears each bit written as 1, and bits written as 0 keep their value.
- R4: When a rising source edge and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R5: A clear applies only to the addressed target. The same source's pending bit in the other targets is unaffected.
- R6: `irq_o[t]` equals the OR over both banks of (target t pending AND target t enable), as registered one cycle after that state. Target t drives `irq_o` bit t.
- R7: `fiq_o` equals the OR over both banks of (I/O-target pending AND fast-interrupt enable), registered one cycle later, and it is independent of the I/O target's normal enables.
- R8: Enable and fast-interrupt enable registers store and return all 32 bits written.
- R9: Address map (byte offsets). Target t (0..2 application cores, 3 I/O processor) occupies 0x10*t, and within the group: +0x0 pending legacy, +0x4 pending extended, +0x8 enable legacy, +0xC enable extended. The fast-interrupt enables are at 0x40 (legacy) and 0x44 (extended).
- R10: Reads of any other offset, including offsets with low bits not 00, return zero, and writes to them change no register.
- R11: `bus_rdata_o` holds the addressed register in the cycle after `bus_rd_i` is high and is zero in the cycle after `bus_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_legacy_i | input | 32 | Legacy-bank interrupt sources |
| src_ext_i | input | 32 | Extended-bank interrupt sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 4 | Interrupt line per target |
| fiq_o | output | 1 | Fast-interrupt line of the I/O-processor target |

## Verification
Two functions can land on the same pending bit in the same clock edge: a source's rising edge setting the bit, and a software write-one-to-clear removing it. The bench produces this collision by raising a source line and issuing the clearing write at the same falling edge, so both are sampled at one rising edge. The bit is then read back and must still be set, while the other targets must also show it set. A second case runs a clear on one target while the others keep the bit, to show that the clear does not reach across targets.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // two source banks: index 0 = legacy, index 1 = extended
  localparam int NUM_BANKS   = 2;
  // bytes occupied by one target's register group
  localparam int GROUP_BYTES = 16;
  // byte stride between banks inside a group
  localparam int WORD_BYTES  = 4;
endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank #(
  parameter int BANK_W    = 32,
  parameter int NUM_BANKS = 2,
  parameter bit HAS_FIQ   = 1'b0,
  localparam int FW       = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [FW-1:0]        rise_i,
  input  logic [NUM_BANKS-1:0] clr_str_i,
  input  logic [NUM_BANKS-1:0] en_str_i,
  input  logic [NUM_BANKS-1:0] fen_str_i,
  input  logic [BANK_W-1:0]    wdata_i,
  output logic [FW-1:0]        pend_o,
  output logic [FW-1:0]        en_o,
  output logic [FW-1:0]        fen_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  logic [FW-1:0] pend_q, en_q, fen_q, clr_mask;
  logic          irq_q, fiq_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign clr_mask[b*BANK_W +: BANK_W] = clr_str_i[b] ? wdata_i : '0;

    always_ff @(posedge clk) begin
      if (rst)              en_q[b*BANK_W +: BANK_W] <= '0;
      else if (en_str_i[b]) en_q[b*BANK_W +: BANK_W] <= wdata_i;
    end
  end

  // set has priority: rise is ORed after the clear mask
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | rise_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_q & en_q);
  end

  if (HAS_FIQ) begin : g_fiq
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_fbank
      always_ff @(posedge clk) begin
        if (rst)               fen_q[b*BANK_W +: BANK_W] <= '0;
        else if (fen_str_i[b]) fen_q[b*BANK_W +: BANK_W] <= wdata_i;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) fiq_q <= 1'b0;
      else     fiq_q <= |(pend_q & fen_q);
    end

    assert_fiq_follows_R7: assert property (@(posedge clk) disable iff (rst)
      fiq_q == $past(|(pend_q & fen_q)))
      else $error("fast-interrupt line does not follow pending and fast enables");
  end else begin : g_nofiq
    logic unused_fen;
    assign unused_fen = ^fen_str_i;
    assign fen_q      = '0;
    assign fiq_q      = 1'b0;
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign fen_o  = fen_q;
  assign irq_o  = irq_q;
  assign fiq_o  = fiq_q;

  assert_rise_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|rise_i) |=> ((pend_q & $past(rise_i)) == $past(rise_i)))
    else $error("rising source edge did not set pending");

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (|(rise_i & clr_mask)) |=> ((pend_q & $past(rise_i & clr_mask)) == $past(rise_i & clr_mask)))
    else $error("clear won against a simultaneous set");

  assert_clear_works_R3: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((pend_q & $past(clr_mask & ~rise_i)) == '0))
    else $error("write-one-to-clear left a bit pending");

  assert_only_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_q) & ~pend_q & ~$past(clr_mask)) == '0)
    else $error("pending bit dropped without a clear");

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q == $past(|(pend_q & en_q)))
    else $error("interrupt line does not follow pending and enables");
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int BANK_W  = 32,
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] src_legacy_i,
  input  logic [BANK_W-1:0] src_ext_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BANK_W-1:0] bus_wdata_i,
  output logic [BANK_W-1:0] bus_rdata_o,
  output logic [NUM_TGT-1:0] irq_o,
  output logic              fiq_o
);
  localparam int FW       = NUM_BANKS * BANK_W;
  localparam int TGT_BITS = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam int TGT_LSB  = $clog2(GROUP_BYTES);
  localparam int IO_TGT   = NUM_TGT - 1;
  localparam int PER_TGT  = 3 * NUM_BANKS;
  localparam int NUM_STR  = NUM_TGT * PER_TGT;
  localparam logic [ADDR_W-1:0] FIQ_BASE = ADDR_W'(NUM_TGT * GROUP_BYTES);

  logic [FW-1:0] src_all, rise_all;
  logic [FW-1:0] pend_a [NUM_TGT];
  logic [FW-1:0] en_a   [NUM_TGT];
  logic [FW-1:0] fen_a  [NUM_TGT];
  logic [NUM_TGT-1:0] fiq_a;
  logic [NUM_STR-1:0] all_str;

  assign src_all = {src_ext_i, src_legacy_i};

  irq_rise_detect #(.W(FW)) i_rise (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src_all),
    .rise_o (rise_all)
  );

  // address decode
  logic                in_tgt, aligned, slot_is_en, slot_bank;
  logic [TGT_BITS-1:0] addr_tgt;
  logic [NUM_BANKS-1:0] fiq_hit;

  assign aligned    = (bus_addr_i[1:0] == 2'b00);
  assign in_tgt     = aligned && (bus_addr_i < FIQ_BASE);
  assign addr_tgt   = bus_addr_i[TGT_LSB +: TGT_BITS];
  assign slot_is_en = bus_addr_i[3];
  assign slot_bank  = bus_addr_i[2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_fhit
    assign fiq_hit[b] = (bus_addr_i == FIQ_BASE + ADDR_W'(b * WORD_BYTES));
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic sel;
    logic [NUM_BANKS-1:0] clr_str, en_str, fen_str;
    assign sel = bus_wr_i && in_tgt && (addr_tgt == TGT_BITS'(t));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_str
      assign clr_str[b] = sel && !slot_is_en && (slot_bank == 1'(b));
      assign en_str[b]  = sel &&  slot_is_en && (slot_bank == 1'(b));
      if (t == IO_TGT) begin : g_f
        assign fen_str[b] = bus_wr_i && fiq_hit[b];
      end else begin : g_nf
        assign fen_str[b] = 1'b0;
      end
    end

    assign all_str[t*PER_TGT +: PER_TGT] = {fen_str, en_str, clr_str};

    irq_target_bank #(
      .BANK_W    (BANK_W),
      .NUM_BANKS (NUM_BANKS),
      .HAS_FIQ   (t == IO_TGT)
    ) i_tgt (
      .clk       (clk),
      .rst       (rst),
      .rise_i    (rise_all),
      .clr_str_i (clr_str),
      .en_str_i  (en_str),
      .fen_str_i (fen_str),
      .wdata_i   (bus_wdata_i),
      .pend_o    (pend_a[t]),
      .en_o      (en_a[t]),
      .fen_o     (fen_a[t]),
      .irq_o     (irq_o[t]),
      .fiq_o     (fiq_a[t])
    );
  end

  assign fiq_o = fiq_a[IO_TGT];

  logic unused_fiq;
  assign unused_fiq = ^fiq_a;

  // read mux
  logic [BANK_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_tgt) begin
      for (int t = 0; t < NUM_TGT; t++) begin
        if (addr_tgt == TGT_BITS'(t)) begin
          if (slot_is_en) rd_mux = en_a[t][slot_bank*BANK_W +: BANK_W];
          else            rd_mux = pend_a[t][slot_bank*BANK_W +: BANK_W];
        end
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (fiq_hit[b]) rd_mux = fen_a[IO_TGT][b*BANK_W +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
    else               bus_rdata_o <= '0;
  end

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(all_str))
    else $error("one write reached more than one register");

  assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && !in_tgt && !(|fiq_hit)) |-> (all_str == '0))
    else $error("write to unmapped offset reached a register");

  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_i |=> (bus_rdata_o == '0))
    else $error("read data not zero after idle cycle");
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_legacy = '0, src_ext = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  logic        fiq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_router i_irq_router (
    .clk          (clk),
    .rst          (rst),
    .src_legacy_i (src_legacy),
    .src_ext_i    (src_ext),
    .bus_wr_i     (bus_wr),
    .bus_rd_i     (bus_rd),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .irq_o        (irq),
    .fiq_o        (fiq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input bit ext, input int n);
    @(negedge clk);
    if (ext) src_ext[n] = 1'b1; else src_legacy[n] = 1'b1;
    @(negedge clk);
    if (ext) src_ext[n] = 1'b0; else src_legacy[n] = 1'b0;
  endtask

  task automatic clear_all();
    for (int t = 0; t < 4; t++) begin
      wr(8'(t*16 + 0),  32'hFFFF_FFFF);
      wr(8'(t*16 + 4),  32'hFFFF_FFFF);
      wr(8'(t*16 + 8),  32'h0);
      wr(8'(t*16 + 12), 32'h0);
    end
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {28'h0, irq}, 32'h0);
    chk("R1 fiq after reset", {31'h0, fiq}, 32'h0);
    for (int a = 0; a < 8'h48; a += 4) rd_chk("R1 register after reset", 8'(a), 32'h0);
  endtask

  task automatic t_enable_rw();
    clear_all();
    wr(8'h18, 32'hA5A5_0F0F);
    wr(8'h3C, 32'h1234_5678);
    wr(8'h40, 32'hDEAD_BEEF);
    wr(8'h44, 32'h8000_0001);
    rd_chk("R8 R9 target1 legacy enable", 8'h18, 32'hA5A5_0F0F);
    rd_chk("R8 R9 target3 ext enable",    8'h3C, 32'h1234_5678);
    rd_chk("R8 R9 fast legacy enable",    8'h40, 32'hDEAD_BEEF);
    rd_chk("R8 R9 fast ext enable",       8'h44, 32'h8000_0001);
    rd_chk("R9 target1 ext enable untouched", 8'h1C, 32'h0);
  endtask

  task automatic t_edge_set();
    clear_all();
    pulse(1'b0, 5);
    pulse(1'b1, 9);
    for (int t = 0; t < 4; t++) begin
      rd_chk("R2 legacy pending per target", 8'(t*16),     32'h0000_0020);
      rd_chk("R2 ext pending per target",    8'(t*16 + 4), 32'h0000_0200);
    end
  endtask

  task automatic t_w1c();
    clear_all();
    pulse(1'b0, 5);
    pulse(1'b0, 6);
    wr(8'h00, 32'h0);
    rd_chk("R3 write zero keeps pending", 8'h00, 32'h0000_0060);
    wr(8'h00, 32'h0000_0020);
    rd_chk("R3 write one clears only that bit", 8'h00, 32'h0000_0040);
    rd_chk("R5 other target keeps pending", 8'h10, 32'h0000_0060);
    rd_chk("R5 io target keeps pending",    8'h30, 32'h0000_0060);
  endtask

  task automatic t_level_held();
    clear_all();
    @(negedge clk);
    src_ext[3] = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h04, 32'h0000_0008);
    repeat (3) @(negedge clk);
    rd_chk("R2 held level does not re-set", 8'h04, 32'h0);
    rd_chk("R2 held level other target",    8'h14, 32'h0000_0008);
    @(negedge clk);
    src_ext[3] = 1'b0;
  endtask

  task automatic t_set_wins();
    clear_all();
    @(negedge clk);
    src_legacy[7] = 1'b1;
    bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h0000_0080;
    @(negedge clk);
    bus_wr = 1'b0;
    src_legacy[7] = 1'b0;
    rd_chk("R4 set wins over clear", 8'h30, 32'h0000_0080);
    rd_chk("R4 other target also set", 8'h20, 32'h0000_0080);
  endtask

  task automatic t_irq();
    clear_all();
    pulse(1'b0, 5);
    wr(8'h28, 32'h0000_0020);
    chk("R6 irq not yet in write cycle", {28'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 target2 irq from legacy", {28'h0, irq}, 32'h4);
    wr(8'h20, 32'h0000_0020);
    @(negedge clk);
    chk("R6 irq drops after clear", {28'h0, irq}, 32'h0);
    pulse(1'b1, 30);
    wr(8'h0C, 32'h4000_0000);
    @(negedge clk);
    chk("R6 target0 irq from ext bank", {28'h0, irq}, 32'h1);
  endtask

  task automatic t_fiq();
    clear_all();
    pulse(1'b1, 2);
    wr(8'h44, 32'h0000_0004);
    @(negedge clk);
    chk("R7 fiq from fast enable", {31'h0, fiq}, 32'h1);
    chk("R7 irq stays low",       {28'h0, irq}, 32'h0);
    wr(8'h3C, 32'h0000_0004);
    @(negedge clk);
    chk("R7 io irq with own enable", {28'h0, irq}, 32'h8);
    wr(8'h34, 32'h0000_0004);
    @(negedge clk);
    chk("R7 fiq drops after clear", {31'h0, fiq}, 32'h0);
    chk("R6 io irq drops after clear", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_unmapped();
    clear_all();
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h09, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped read zero", 8'h48, 32'h0);
    rd_chk("R10 misaligned read zero", 8'h0A, 32'h0);
    for (int t = 0; t < 4; t++) begin
      rd_chk("R10 enable legacy unchanged", 8'(t*16 + 8),  32'h0);
      rd_chk("R10 enable ext unchanged",    8'(t*16 + 12), 32'h0);
    end
    rd_chk("R10 fast enable unchanged", 8'h40, 32'h0);
  endtask

  task automatic t_read_timing();
    clear_all();
    wr(8'h08, 32'h0000_BEEF);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h08;
    @(negedge clk);
    chk("R11 data one cycle after read", bus_rdata, 32'h0000_BEEF);
    bus_rd = 1'b0;
    @(negedge clk);
    chk("R11 data zero when idle", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_edge_set();
    t_w1c();
    t_level_held();
    t_set_wins();
    t_irq();
    t_fiq();
    t_unmapped();
    t_read_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule